// File: doc/BRIEF.md
# Parallel-to-Serial Line Scan Buffer

The block holds one scan line of up to 320 sixteen-bit words and turns it into a serial bit stream. Words come in from a host bus, qualified by a select and a write strobe, or from a DMA engine through a request/acknowledge handshake. A select input marks each host word as a command or as line data. A start command sends the line. The stream may begin with a programmable run of constant bits, all ones or all zeros. The stored words can be read back in the order they were written or in reverse.

Each bit moves out on a bit tick. The tick comes from one of two sources: a divider on the system clock (1, 2, 4, 8 or 16 cycles per bit), or the rising edges of a request line driven by the receiving peripheral. The request line is brought into the system clock domain by a synchronizer. A clock-enable input freezes progress. A busy flag covers the whole transmission. A one-cycle interrupt marks the last bit, and at that point the buffer becomes empty and is ready for the next line.

Top module: `line_scan_serializer`

## Requirements
- R1: A host command write (select, strobe and command all high) decodes bits [15:13] as the target. 0 is the mode register: bit 0 reverse order, bit 1 external tick source, bits [4:2] divider code, bit 5 fixed-bit level. 1 is the fixed-bit count in bits [12:0]. 2 is the DMA threshold in bits [8:0]. 3 is start. Every register resets to zero.
- R2: In forward order, words leave in the order written, each word most significant bit first.
- R3: In reverse order, the last word written leaves first, each word least significant bit first.
- R4: A fixed-bit count of N puts N bits at the mode's level before the stored data. A count of zero adds none.
- R5: With the internal source, divider code c gives one bit every 2^c system cycles. Codes of 4 and above give 16.
- R6: With the external source, each rising edge of the request input releases exactly one bit. No bit leaves without an edge.
- R7: While the clock enable is low, no bit is emitted and the transmission stays busy.
- R8: Busy is high from start until the last bit. The interrupt is high for one cycle, together with the last bit's strobe, with busy low. The buffer is then empty.
- R9: The DMA request is high while not busy and the stored count is below the threshold. A write with DMA acknowledge stores a data word without the select input.
- R10: Data writes beyond 320 stored words are ignored.
- R11: While busy, every data and command write is ignored.
- R12: After reset, busy, interrupt, strobe, serial data and DMA request are all low.
- R13: A start with no stored words and a zero fixed-bit count is ignored.
- R14: A data write in the cycle the interrupt is high becomes word 0 of the next line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Host select |
| bus_wr_i | input | 1 | Write strobe, one word per cycle |
| bus_cmd_i | input | 1 | 1: command word, 0: line data |
| bus_data_i | input | 16 | Write data |
| dma_ack_i | input | 1 | DMA acknowledge, qualifies a data write |
| dma_req_o | output | 1 | DMA request |
| clk_en_i | input | 1 | Bit progress enable |
| ext_req_i | input | 1 | Peripheral bit request, rising edge active |
| ser_data_o | output | 1 | Serial data |
| ser_stb_o | output | 1 | One-cycle pulse per new serial bit |
| busy_o | output | 1 | Transmission in progress |
| irq_o | output | 1 | One-cycle pulse with the last bit |

## Verification
The end of a line and a new data write can fall in the same cycle. When the interrupt rises, the stored count is cleared, and a write in that same cycle must land at address 0 instead of after the old line. The bench provokes this by waiting for the interrupt at the falling edge and driving a data write in that very cycle. It then sends a second line and checks that the line is exactly that one word, 16 bits long and bit for bit correct.

// File: rtl/lsb_pkg.sv
`timescale 1ns/1ps
package lsb_pkg;
    localparam int WORD_W = 16;
    localparam int SEL_W  = 3;
    localparam int FIX_W  = WORD_W - SEL_W;
    localparam int BIT_W  = $clog2(WORD_W);

    localparam logic [SEL_W-1:0] TGT_MODE   = 3'd0;
    localparam logic [SEL_W-1:0] TGT_FIXLEN = 3'd1;
    localparam logic [SEL_W-1:0] TGT_THRESH = 3'd2;
    localparam logic [SEL_W-1:0] TGT_START  = 3'd3;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FIXED = 2'd1,
        PH_DATA  = 2'd2
    } phase_e;

    // packed MSB first: bit5 level, bits4:2 divider, bit1 external, bit0 reverse
    typedef struct packed {
        logic       fix_level;
        logic [2:0] div_code;
        logic       ext_src;
        logic       reverse;
    } mode_t;
endpackage

// File: rtl/lsb_line_mem.sv
`timescale 1ns/1ps
module lsb_line_mem #(
    parameter int DEPTH  = 320,
    parameter int WIDTH  = 16,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [WIDTH-1:0]  wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [WIDTH-1:0]  rdata_o
);
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/lsb_bus_regs.sv
`timescale 1ns/1ps
module lsb_bus_regs
    import lsb_pkg::*;
#(
    parameter int DEPTH  = 320,
    parameter int ADDR_W = $clog2(DEPTH),
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                bus_sel_i,
    input  logic                bus_wr_i,
    input  logic                bus_cmd_i,
    input  logic [WORD_W-1:0]   bus_data_i,
    input  logic                dma_ack_i,
    input  logic                busy_i,
    input  logic                line_done_i,
    output mode_t               mode_o,
    output logic [FIX_W-1:0]    fix_len_o,
    output logic [CNT_W-1:0]    word_count_o,
    output logic                mem_we_o,
    output logic [ADDR_W-1:0]   mem_waddr_o,
    output logic                start_o,
    output logic                dma_req_o
);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    typedef struct packed {
        mode_t             mode;
        logic [FIX_W-1:0]  fix_len;
        logic [CNT_W-1:0]  thresh;
        logic [CNT_W-1:0]  count;
    } regs_t;

    regs_t q, d;
    logic host_wr, dma_wr, data_wr, cmd_wr;
    logic [CNT_W-1:0] base_count;
    logic [SEL_W-1:0] target;

    always_comb begin
        host_wr    = bus_sel_i && bus_wr_i && !dma_ack_i;
        dma_wr     = dma_ack_i && bus_wr_i;
        data_wr    = (host_wr && !bus_cmd_i) || dma_wr;
        cmd_wr     = host_wr && bus_cmd_i;
        target     = bus_data_i[WORD_W-1 -: SEL_W];
        base_count = line_done_i ? '0 : q.count;

        d          = q;
        d.count    = base_count;
        mem_we_o   = 1'b0;
        start_o    = 1'b0;

        if (!busy_i) begin
            if (data_wr && (base_count < DEPTH_C)) begin
                mem_we_o = 1'b1;
                d.count  = base_count + CNT_W'(1);
            end
            if (cmd_wr) begin
                case (target)
                    TGT_MODE:   d.mode    = mode_t'(bus_data_i[5:0]);
                    TGT_FIXLEN: d.fix_len = bus_data_i[FIX_W-1:0];
                    TGT_THRESH: d.thresh  = bus_data_i[CNT_W-1:0];
                    TGT_START:  start_o   = (base_count != '0) || (q.fix_len != '0);
                    default:    ;
                endcase
            end
        end

        mem_waddr_o  = base_count[ADDR_W-1:0];
        dma_req_o    = !busy_i && (base_count < q.thresh);
        mode_o       = q.mode;
        fix_len_o    = q.fix_len;
        word_count_o = base_count;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assert_no_overflow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.count <= DEPTH_C);
    assert_count_frozen_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_i |=> (q.count == $past(q.count)));
    assert_mode_frozen_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_i |=> (q.mode == $past(q.mode)) && (q.fix_len == $past(q.fix_len)));
    assert_dreq_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dma_req_o |-> !busy_i);
endmodule

// File: rtl/lsb_bit_timer.sv
`timescale 1ns/1ps
module lsb_bit_timer #(
    parameter int MAX_CODE = 4,
    parameter int CODE_W   = 3,
    parameter int DIV_W    = MAX_CODE
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              busy_i,
    input  logic              clk_en_i,
    input  logic              ext_src_i,
    input  logic [CODE_W-1:0] div_code_i,
    input  logic              ext_req_i,
    output logic              tick_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             s1;
        logic             s2;
        logic             s3;
    } tmr_t;

    tmr_t q, d;
    logic [DIV_W-1:0] div_last;
    logic             ext_edge;

    always_comb begin
        if (div_code_i >= CODE_W'(MAX_CODE)) div_last = '1;
        else div_last = DIV_W'((1 << div_code_i) - 1);

        ext_edge = q.s2 && !q.s3;
        d        = q;
        d.s1     = ext_req_i;
        d.s2     = q.s1;
        d.s3     = q.s2;
        tick_o   = 1'b0;

        if (!busy_i) begin
            d.cnt = '0;
        end else if (clk_en_i) begin
            if (ext_src_i) begin
                tick_o = ext_edge;
            end else if (q.cnt == div_last) begin
                tick_o = 1'b1;
                d.cnt  = '0;
            end else begin
                d.cnt = q.cnt + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    // a tick from the request line needs a fresh rising edge two cycles back
    assert_ext_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_o && ext_src_i) |-> ($past(ext_req_i, 2) && !$past(ext_req_i, 3)));
endmodule

// File: rtl/lsb_serializer.sv
`timescale 1ns/1ps
module lsb_serializer
    import lsb_pkg::*;
#(
    parameter int DEPTH  = 320,
    parameter int ADDR_W = $clog2(DEPTH),
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  mode_t             mode_i,
    input  logic [FIX_W-1:0]  fix_len_i,
    input  logic [CNT_W-1:0]  word_count_i,
    input  logic              tick_i,
    input  logic [WORD_W-1:0] rd_word_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              busy_o,
    output logic              ser_data_o,
    output logic              ser_stb_o,
    output logic              irq_o
);
    localparam logic [BIT_W-1:0] BIT_TOP = BIT_W'(WORD_W - 1);

    typedef struct packed {
        phase_e            phase;
        logic [FIX_W-1:0]  fix_left;
        logic [CNT_W-1:0]  words_left;
        logic [ADDR_W-1:0] word_idx;
        logic [BIT_W-1:0]  bit_idx;
        logic              data;
        logic              stb;
        logic              irq;
    } ser_t;

    ser_t q, d;
    logic last_bit;

    always_comb begin
        d        = q;
        d.stb    = 1'b0;
        d.irq    = 1'b0;
        last_bit = mode_i.reverse ? (q.bit_idx == BIT_TOP) : (q.bit_idx == '0);

        case (q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    d.words_left = word_count_i;
                    d.word_idx   = mode_i.reverse ? ADDR_W'(word_count_i - CNT_W'(1)) : '0;
                    d.bit_idx    = mode_i.reverse ? '0 : BIT_TOP;
                    d.fix_left   = fix_len_i;
                    d.phase      = (fix_len_i != '0) ? PH_FIXED : PH_DATA;
                end
            end
            PH_FIXED: begin
                if (tick_i) begin
                    d.data     = mode_i.fix_level;
                    d.stb      = 1'b1;
                    d.fix_left = q.fix_left - FIX_W'(1);
                    if (q.fix_left == FIX_W'(1)) begin
                        if (q.words_left == '0) begin
                            d.phase = PH_IDLE;
                            d.irq   = 1'b1;
                        end else begin
                            d.phase = PH_DATA;
                        end
                    end
                end
            end
            PH_DATA: begin
                if (tick_i) begin
                    d.data = rd_word_i[q.bit_idx];
                    d.stb  = 1'b1;
                    if (!last_bit) begin
                        d.bit_idx = mode_i.reverse ? q.bit_idx + BIT_W'(1)
                                                   : q.bit_idx - BIT_W'(1);
                    end else begin
                        d.bit_idx    = mode_i.reverse ? '0 : BIT_TOP;
                        d.words_left = q.words_left - CNT_W'(1);
                        d.word_idx   = mode_i.reverse ? q.word_idx - ADDR_W'(1)
                                                      : q.word_idx + ADDR_W'(1);
                        if (q.words_left == CNT_W'(1)) begin
                            d.phase = PH_IDLE;
                            d.irq   = 1'b1;
                        end
                    end
                end
            end
            default: d.phase = PH_IDLE;
        endcase

        rd_addr_o  = q.word_idx;
        busy_o     = (q.phase != PH_IDLE);
        ser_data_o = q.data;
        ser_stb_o  = q.stb;
        irq_o      = q.irq;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assert_irq_ends_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (!busy_o && $past(busy_o)));
    assert_irq_with_bit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> ser_stb_o);
    assert_bit_needs_tick_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ser_stb_o |-> $past(tick_i));
    assert_irq_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |=> !irq_o);
endmodule

// File: rtl/line_scan_serializer.sv
`timescale 1ns/1ps
module line_scan_serializer
    import lsb_pkg::*;
#(
    parameter int DEPTH = 320
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        bus_sel_i,
    input  logic        bus_wr_i,
    input  logic        bus_cmd_i,
    input  logic [15:0] bus_data_i,
    input  logic        dma_ack_i,
    output logic        dma_req_o,
    input  logic        clk_en_i,
    input  logic        ext_req_i,
    output logic        ser_data_o,
    output logic        ser_stb_o,
    output logic        busy_o,
    output logic        irq_o
);
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int CNT_W  = $clog2(DEPTH + 1);

    mode_t              mode;
    logic [FIX_W-1:0]   fix_len;
    logic [CNT_W-1:0]   word_count;
    logic               mem_we, start, tick, busy, irq;
    logic [ADDR_W-1:0]  mem_waddr, rd_addr;
    logic [WORD_W-1:0]  rd_word;

    lsb_bus_regs #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .bus_sel_i(bus_sel_i), .bus_wr_i(bus_wr_i), .bus_cmd_i(bus_cmd_i),
        .bus_data_i(bus_data_i), .dma_ack_i(dma_ack_i),
        .busy_i(busy), .line_done_i(irq),
        .mode_o(mode), .fix_len_o(fix_len), .word_count_o(word_count),
        .mem_we_o(mem_we), .mem_waddr_o(mem_waddr),
        .start_o(start), .dma_req_o(dma_req_o)
    );

    lsb_line_mem #(.DEPTH(DEPTH), .WIDTH(WORD_W), .ADDR_W(ADDR_W)) u_mem (
        .clk_i(clk_i), .we_i(mem_we), .waddr_i(mem_waddr), .wdata_i(bus_data_i),
        .raddr_i(rd_addr), .rdata_o(rd_word)
    );

    lsb_bit_timer u_timer (
        .clk_i(clk_i), .rst_ni(rst_ni), .busy_i(busy), .clk_en_i(clk_en_i),
        .ext_src_i(mode.ext_src), .div_code_i(mode.div_code),
        .ext_req_i(ext_req_i), .tick_o(tick)
    );

    lsb_serializer #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ser (
        .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .mode_i(mode),
        .fix_len_i(fix_len), .word_count_i(word_count), .tick_i(tick),
        .rd_word_i(rd_word), .rd_addr_o(rd_addr), .busy_o(busy),
        .ser_data_o(ser_data_o), .ser_stb_o(ser_stb_o), .irq_o(irq)
    );

    assign busy_o = busy;
    assign irq_o  = irq;
endmodule

// File: tb/line_scan_serializer_tb_top.sv
`timescale 1ns/1ps
module line_scan_serializer_tb_top;
    logic clk = 1'b0, rst_n = 1'b0;
    logic sel = 1'b0, wr = 1'b0, cmd = 1'b0, dack = 1'b0, clk_en = 1'b1, ext_req = 1'b0;
    logic [15:0] data = '0;
    logic dma_req, ser_data, ser_stb, busy, irq;
    int tests = 0, fails = 0, cyc = 0;
    bit finished = 0;

    line_scan_serializer dut_i (
        .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_wr_i(wr), .bus_cmd_i(cmd),
        .bus_data_i(data), .dma_ack_i(dack), .dma_req_o(dma_req), .clk_en_i(clk_en),
        .ext_req_i(ext_req), .ser_data_o(ser_data), .ser_stb_o(ser_stb),
        .busy_o(busy), .irq_o(irq)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct packed {
        logic       rev;
        logic       lvl;
        logic [2:0] divc;
        logic [7:0] flen;
        logic [3:0] nw;
        logic [7:0] seed;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b0, 3'd0, 8'd0,  4'd3, 8'd1},
        '{1'b1, 1'b0, 3'd0, 8'd0,  4'd3, 8'd2},
        '{1'b0, 1'b1, 3'd1, 8'd5,  4'd2, 8'd3},
        '{1'b1, 1'b0, 3'd2, 8'd17, 4'd1, 8'd4},
        '{1'b0, 1'b1, 3'd3, 8'd3,  4'd0, 8'd5},
        '{1'b0, 1'b0, 3'd4, 8'd0,  4'd2, 8'd6},
        '{1'b1, 1'b1, 3'd7, 8'd1,  4'd1, 8'd7}
    };

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    initial begin
        wait (cyc >= 150000);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 150000);
            summary();
            $finish;
        end
    end

    function automatic logic [15:0] word_of(int seed, int i);
        return 16'((seed * 467 + i * 40503) ^ (i << 5) ^ (seed << 11));
    endfunction

    function automatic logic exp_bit(int k, bit rev, bit lvl, int flen, int nw, int seed);
        int j, w, b;
        if (k < flen) return lvl;
        j = k - flen; w = j / 16; b = j % 16;
        if (rev) return word_of(seed, nw - 1 - w)[b];
        return word_of(seed, w)[15 - b];
    endfunction

    task automatic bus_write(input bit c, input logic [15:0] v);
        @(negedge clk); sel = 1; wr = 1; cmd = c; data = v;
        @(negedge clk); sel = 0; wr = 0; cmd = 0;
    endtask

    task automatic dma_write(input logic [15:0] v);
        @(negedge clk); dack = 1; wr = 1; data = v;
        @(negedge clk); dack = 0; wr = 0;
    endtask

    task automatic set_reg(input int tgt, input int val);
        bus_write(1'b1, 16'((tgt << 13) | val));
    endtask

    task automatic set_mode(input bit rev, input bit ext, input int divc, input bit lvl);
        set_reg(0, (int'(lvl) << 5) | (divc << 2) | (int'(ext) << 1) | int'(rev));
    endtask

    task automatic load_line(input int seed, input int n);
        for (int i = 0; i < n; i++) bus_write(1'b0, word_of(seed, i));
    endtask

    // returns at the falling edge of the interrupt cycle
    task automatic collect(input bit rev, input bit lvl, input int flen, input int nw,
                           input int seed, input int period, output int nbits,
                           output int bad, output int badgap, output bit irq_ok);
        int last, guard;
        last = -1; guard = cyc + 60000;
        nbits = 0; bad = 0; badgap = 0; irq_ok = 0;
        forever begin
            @(negedge clk);
            if (ser_stb) begin
                if (ser_data !== exp_bit(nbits, rev, lvl, flen, nw, seed)) bad++;
                if (period > 0 && last >= 0 && (cyc - last) != period) badgap++;
                last = cyc;
                nbits++;
            end
            if (irq) begin
                irq_ok = ser_stb && !busy;
                break;
            end
            if (cyc > guard) break;
        end
    endtask

    task automatic line_checks(input string req, input int nbits, input int expn,
                               input int bad, input bit irq_ok);
        check(nbits == expn, req, "bit count", nbits, expn);
        check(bad == 0, req, "bit mismatches", bad, 0);
        check(irq_ok, "R8", "irq with last strobe and busy low", irq_ok, 1);
    endtask

    initial begin
        int nb, bad, gap, per, s0;
        bit iok;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12 reset state
        check(!busy && !irq && !ser_stb && !ser_data, "R12", "outputs after reset",
              {busy, irq, ser_stb, ser_data}, 0);
        check(!dma_req, "R12", "dma request after reset", dma_req, 0);
        // R13 empty start
        set_reg(3, 0);
        repeat (3) @(negedge clk);
        check(!busy, "R13", "start with empty line", busy, 0);

        // table-driven lines: R1 R2 R3 R4 R5
        for (int v = 0; v < NVEC; v++) begin
            per = (VECS[v].divc >= 4) ? 16 : (1 << VECS[v].divc);
            set_mode(VECS[v].rev, 1'b0, int'(VECS[v].divc), VECS[v].lvl);
            set_reg(1, int'(VECS[v].flen));
            load_line(int'(VECS[v].seed), int'(VECS[v].nw));
            set_reg(3, 0);
            collect(VECS[v].rev, VECS[v].lvl, int'(VECS[v].flen), int'(VECS[v].nw),
                    int'(VECS[v].seed), per, nb, bad, gap, iok);
            line_checks(VECS[v].rev ? "R1/R3/R4" : "R1/R2/R4", nb,
                        int'(VECS[v].flen) + 16 * int'(VECS[v].nw), bad, iok);
            check(gap == 0, "R5", "strobe spacing", gap, 0);
        end

        // R8 buffer empty after line: start with no fixed bits is ignored
        set_reg(1, 0);
        set_reg(3, 0);
        repeat (3) @(negedge clk);
        check(!busy, "R8", "buffer empty after line", busy, 0);

        // R9 DMA fill
        set_reg(2, 3);
        @(negedge clk);
        check(dma_req, "R9", "request below threshold", dma_req, 1);
        dma_write(word_of(9, 0));
        dma_write(word_of(9, 1));
        check(dma_req, "R9", "request at two of three", dma_req, 1);
        dma_write(word_of(9, 2));
        check(!dma_req, "R9", "request released at threshold", dma_req, 0);
        set_mode(1'b0, 1'b0, 0, 1'b0);
        set_reg(3, 0);
        check(!dma_req, "R9", "request low while busy", dma_req, 0);
        collect(1'b0, 1'b0, 0, 3, 9, 1, nb, bad, gap, iok);
        line_checks("R9", nb, 48, bad, iok);
        set_reg(2, 0);

        // R11 writes while busy are ignored
        set_mode(1'b0, 1'b0, 2, 1'b0);
        load_line(11, 2);
        set_reg(3, 0);
        fork
            collect(1'b0, 1'b0, 0, 2, 11, 4, nb, bad, gap, iok);
            begin
                set_reg(1, 5);
                set_mode(1'b1, 1'b0, 0, 1'b1);
                bus_write(1'b0, 16'hFFFF);
            end
        join
        line_checks("R11", nb, 32, bad, iok);
        check(gap == 0, "R11", "divider unchanged during busy", gap, 0);
        load_line(12, 1);
        set_reg(3, 0);
        collect(1'b0, 1'b0, 0, 1, 12, 4, nb, bad, gap, iok);
        line_checks("R11", nb, 16, bad, iok);

        // R7 clock enable
        set_mode(1'b0, 1'b0, 0, 1'b0);
        load_line(13, 1);
        clk_en = 0;
        set_reg(3, 0);
        s0 = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (ser_stb) s0++;
        end
        check(s0 == 0, "R7", "strobes while disabled", s0, 0);
        check(busy, "R7", "busy held while disabled", busy, 1);
        clk_en = 1;
        collect(1'b0, 1'b0, 0, 1, 13, 1, nb, bad, gap, iok);
        line_checks("R7", nb, 16, bad, iok);

        // R6 external request
        set_mode(1'b0, 1'b1, 0, 1'b0);
        load_line(14, 1);
        set_reg(3, 0);
        s0 = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (ser_stb) s0++;
        end
        check(s0 == 0, "R6", "no bit without request edge", s0, 0);
        fork
            collect(1'b0, 1'b0, 0, 1, 14, 0, nb, bad, gap, iok);
            for (int p = 0; p < 16; p++) begin
                @(negedge clk); ext_req = 1;
                repeat (2) @(negedge clk);
                ext_req = 0;
                repeat (3) @(negedge clk);
            end
        join
        line_checks("R6", nb, 16, bad, iok);

        // R10 overflow
        set_mode(1'b0, 1'b0, 0, 1'b0);
        load_line(15, 322);
        set_reg(3, 0);
        collect(1'b0, 1'b0, 0, 320, 15, 1, nb, bad, gap, iok);
        line_checks("R10", nb, 5120, bad, iok);

        // R14 write in the interrupt cycle
        load_line(16, 1);
        set_reg(3, 0);
        collect(1'b0, 1'b0, 0, 1, 16, 1, nb, bad, gap, iok);
        line_checks("R14", nb, 16, bad, iok);
        sel = 1; wr = 1; cmd = 0; data = word_of(17, 0);
        @(negedge clk); sel = 0; wr = 0;
        set_reg(3, 0);
        collect(1'b0, 1'b0, 0, 1, 17, 1, nb, bad, gap, iok);
        line_checks("R14", nb, 16, bad, iok);

        finished = 1;
        summary();
        $finish;
    end
endmodule